// File: doc/BRIEF.md
# Ten-State Machine Debug Tap

This block sits beside a ten-state controller whose state register is one-hot. It watches that register and turns it into a 4-bit binary code that a debug probe or a status register can read. Each state's code is its position in the controller's state list. A pattern that is not a single set bit gets a reserved code, so a dead (all-zero) register can never look like the first state.

The one-hot vector is first copied into an isolation register. This keeps the tap from loading the controller's own flops. The code is then encoded and registered in the source clock domain. A copy can be carried into a second clock domain on request. The source domain latches the current code and the illegal flag into a holding register, then flips a request toggle. That toggle passes through a two-stage synchronizer. The destination domain loads the held word one cycle after it sees the toggle change. It then flips an acknowledge toggle, which is synchronized back to the source domain.

A request made while a transfer is still in flight is dropped. There is no queue and no back-pressure signal: a requester that must see a capture happen waits for the destination load pulse and then for the acknowledge round trip before it asks again. All four code bits and the illegal flag arrive in the destination domain as one coherent word.

Top module: `fsm_state_tap`

## Requirements
- R1: Input bit i of `st_onehot` (bit 0 = idle state, then write0, write1, read1, abort0 to abort4, bit 9 = done state) alone set yields `src_code` = i (0x0 to 0x9), with `src_bad` low.
- R2: An all-zero `st_onehot` yields `src_code` = 0xF with `src_bad` high, never 0x0.
- R3: Two or more set bits in `st_onehot` yield `src_code` = 0xF with `src_bad` high.
- R4: `src_code` and `src_bad` reflect the `st_onehot` value sampled two `src_clk` rising edges earlier: one isolation register, then one output register.
- R5: `src_bad` is high exactly when `src_code` is 0xF, and otherwise `src_code` is below 10.
- R6: A `cap_req` sampled high at a `src_clk` edge while no transfer is in flight captures the `src_code` and `src_bad` shown at that edge. That pair later appears together on `dst_code` and `dst_bad`, at the same `dst_clk` edge that raises `dst_new`.
- R7: A `cap_req` sampled while a transfer is in flight is ignored. `dst_code`, `dst_bad` and the count of `dst_new` pulses show no trace of it. A transfer stays in flight until the destination acknowledge has returned through the source synchronizer.
- R8: After reset, `src_code` = 0x0, `src_bad` = 0, `dst_code` = 0x0, `dst_bad` = 0, `dst_valid` = 0 and `dst_new` = 0. Coming out of reset, the isolation register holds the idle pattern.
- R9: `dst_valid` rises with the first `dst_new` and stays high until the destination reset.
- R10: `dst_new` is high for exactly one `dst_clk` cycle per load, and `dst_code` and `dst_bad` change only in a cycle where `dst_new` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Clock of the observed controller |
| src_rst_n | input | 1 | Active-low reset, source domain |
| st_onehot | input | 10 | One-hot state register being watched |
| cap_req | input | 1 | Request to copy the current code to the destination domain |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst_n | input | 1 | Active-low reset, destination domain |
| src_code | output | 4 | Binary state code, source domain |
| src_bad | output | 1 | Illegal pattern flag, source domain |
| dst_code | output | 4 | Captured code, destination domain |
| dst_bad | output | 1 | Captured illegal flag, destination domain |
| dst_valid | output | 1 | At least one capture has been loaded since reset |
| dst_new | output | 1 | One-cycle pulse when a capture is loaded |

## Verification
The bound checker watches, on every cycle, that the flag and the reserved code agree. It also checks that a zero-hot or single-hot input two source edges back gives the matching flag, that the load pulse lasts a single cycle and implies the valid flag, that the valid flag never drops, and that the destination word moves only together with the pulse. What no single-cycle property can show is left to the bench scenarios: that the value delivered across the domains is the one present at the request, that a request made mid-flight leaves no trace, and that a later request is served once the acknowledge has returned. A behavioural model in the bench predicts the source code every source cycle.

// File: rtl/fsm_tap_pkg.sv
package fsm_tap_pkg;
  localparam int unsigned TAP_STATES = 10;
  localparam int unsigned TAP_CODE_W = 4;
  localparam int unsigned TAP_SYNC_N = 2;
endpackage

// File: rtl/tap_sync.sv
module tap_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '0;
        else        chain <= d;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/tap_encoder.sv
module tap_encoder #(
  parameter int unsigned N_ST   = 10,
  parameter int unsigned CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_ST-1:0]   st_in,
  output logic [CODE_W-1:0] code,
  output logic              bad
);
  localparam logic [N_ST-1:0]   ISO_RST  = N_ST'(1);
  localparam logic [CODE_W-1:0] BAD_CODE = '1;

  logic [N_ST-1:0]   iso_q;
  logic [CODE_W-1:0] enc_c;
  logic              bad_c;

  // isolation copy keeps the probe off the observed flops
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) iso_q <= ISO_RST;
    else        iso_q <= st_in;

  always_comb begin
    int unsigned hits;
    int unsigned pos;
    hits = 0;
    pos  = 0;
    for (int unsigned i = 0; i < N_ST; i++) begin
      if (iso_q[i]) begin
        hits = hits + 1;
        pos  = i;
      end
    end
    bad_c = (hits != 1);
    enc_c = bad_c ? BAD_CODE : CODE_W'(pos);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      code <= '0;
      bad  <= 1'b0;
    end else begin
      code <= enc_c;
      bad  <= bad_c;
    end
endmodule

// File: rtl/tap_xfer.sv
module tap_xfer #(
  parameter int unsigned W      = 5,
  parameter int unsigned SYNC_N = 2
) (
  input  logic         src_clk,
  input  logic         src_rst_n,
  input  logic         cap_req,
  input  logic [W-1:0] src_word,
  input  logic         dst_clk,
  input  logic         dst_rst_n,
  output logic [W-1:0] dst_word,
  output logic         dst_valid,
  output logic         dst_new
);
  // source side
  logic [W-1:0] hold_q;
  logic         req_tgl;
  logic         ack_s;
  logic         busy;

  assign busy = req_tgl ^ ack_s;

  always_ff @(posedge src_clk or negedge src_rst_n)
    if (!src_rst_n) begin
      hold_q  <= '0;
      req_tgl <= 1'b0;
    end else if (cap_req && !busy) begin
      hold_q  <= src_word;
      req_tgl <= ~req_tgl;
    end

  // destination side
  logic req_s, req_seen, ld_q, ack_tgl;

  tap_sync #(.STAGES(SYNC_N)) u_req_sync (
    .clk(dst_clk), .rst_n(dst_rst_n), .d(req_tgl), .q(req_s)
  );

  always_ff @(posedge dst_clk or negedge dst_rst_n)
    if (!dst_rst_n) begin
      req_seen  <= 1'b0;
      ld_q      <= 1'b0;
      ack_tgl   <= 1'b0;
      dst_word  <= '0;
      dst_valid <= 1'b0;
      dst_new   <= 1'b0;
    end else begin
      req_seen <= req_s;
      ld_q     <= req_s ^ req_seen;
      dst_new  <= ld_q;
      if (ld_q) begin
        dst_word  <= hold_q;
        dst_valid <= 1'b1;
        ack_tgl   <= ~ack_tgl;
      end
    end

  tap_sync #(.STAGES(SYNC_N)) u_ack_sync (
    .clk(src_clk), .rst_n(src_rst_n), .d(ack_tgl), .q(ack_s)
  );
endmodule

// File: rtl/fsm_state_tap.sv
module fsm_state_tap
  import fsm_tap_pkg::*;
#(
  parameter int unsigned N_ST   = TAP_STATES,
  parameter int unsigned CODE_W = TAP_CODE_W,
  parameter int unsigned SYNC_N = TAP_SYNC_N
) (
  input  logic              src_clk,
  input  logic              src_rst_n,
  input  logic [N_ST-1:0]   st_onehot,
  input  logic              cap_req,
  input  logic              dst_clk,
  input  logic              dst_rst_n,
  output logic [CODE_W-1:0] src_code,
  output logic              src_bad,
  output logic [CODE_W-1:0] dst_code,
  output logic              dst_bad,
  output logic              dst_valid,
  output logic              dst_new
);
  localparam int unsigned WORD_W = CODE_W + 1;

  logic [WORD_W-1:0] dst_word;

  tap_encoder #(.N_ST(N_ST), .CODE_W(CODE_W)) u_enc (
    .clk(src_clk), .rst_n(src_rst_n), .st_in(st_onehot),
    .code(src_code), .bad(src_bad)
  );

  tap_xfer #(.W(WORD_W), .SYNC_N(SYNC_N)) u_xfer (
    .src_clk(src_clk), .src_rst_n(src_rst_n), .cap_req(cap_req),
    .src_word({src_bad, src_code}),
    .dst_clk(dst_clk), .dst_rst_n(dst_rst_n),
    .dst_word(dst_word), .dst_valid(dst_valid), .dst_new(dst_new)
  );

  assign dst_bad  = dst_word[WORD_W-1];
  assign dst_code = dst_word[CODE_W-1:0];
endmodule

// File: rtl/fsm_state_tap_chk.sv
module fsm_state_tap_chk #(
  parameter int unsigned N_ST   = 10,
  parameter int unsigned CODE_W = 4
) (
  input logic              src_clk,
  input logic              src_rst_n,
  input logic [N_ST-1:0]   st_onehot,
  input logic              dst_clk,
  input logic              dst_rst_n,
  input logic [CODE_W-1:0] src_code,
  input logic              src_bad,
  input logic [CODE_W-1:0] dst_code,
  input logic              dst_bad,
  input logic              dst_valid,
  input logic              dst_new
);
  logic [1:0] src_age;
  logic       dst_armed;

  always_ff @(posedge src_clk or negedge src_rst_n)
    if (!src_rst_n)          src_age <= '0;
    else if (src_age != 2'd2) src_age <= src_age + 2'd1;

  always_ff @(posedge dst_clk or negedge dst_rst_n)
    if (!dst_rst_n) dst_armed <= 1'b0;
    else            dst_armed <= 1'b1;

  // R5
  flag_code_agree_chk: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    src_bad |-> (src_code == '1));

  // R5
  legal_range_chk: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    !src_bad |-> (src_code < CODE_W'(N_ST)));

  // R2
  zero_hot_flag_chk: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    (src_age == 2'd2 && $past(st_onehot, 2) == '0) |-> (src_bad && src_code == '1));

  // R1
  single_hot_ok_chk: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    (src_age == 2'd2 && $onehot($past(st_onehot, 2))) |-> !src_bad);

  // R10
  pulse_single_chk: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    dst_new |=> !dst_new);

  // R9
  valid_with_pulse_chk: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    dst_new |-> dst_valid);

  // R9
  valid_sticky_chk: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    dst_valid |=> dst_valid);

  // R10
  word_moves_with_pulse_chk: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    (dst_armed && !dst_new) |-> ($stable(dst_code) && $stable(dst_bad)));
endmodule

bind fsm_state_tap fsm_state_tap_chk #(.N_ST(N_ST), .CODE_W(CODE_W)) u_chk (
  .src_clk(src_clk), .src_rst_n(src_rst_n), .st_onehot(st_onehot),
  .dst_clk(dst_clk), .dst_rst_n(dst_rst_n),
  .src_code(src_code), .src_bad(src_bad),
  .dst_code(dst_code), .dst_bad(dst_bad),
  .dst_valid(dst_valid), .dst_new(dst_new)
);

// File: tb/fsm_state_tap_tb.sv
`timescale 1ns/1ps
module fsm_state_tap_tb;
  localparam int N = 10;

  logic       src_clk = 1'b0, dst_clk = 1'b0;
  logic       src_rst_n = 1'b0, dst_rst_n = 1'b0;
  logic [9:0] st_onehot = 10'h001;
  logic       cap_req = 1'b0;
  logic [3:0] src_code, dst_code;
  logic       src_bad, dst_bad, dst_valid, dst_new;

  int errors = 0, checks = 0, pulses = 0;
  bit done = 0;

  always #2 src_clk = ~src_clk;
  initial begin #1; forever #3 dst_clk = ~dst_clk; end

  fsm_state_tap u_dut (
    .src_clk(src_clk), .src_rst_n(src_rst_n), .st_onehot(st_onehot), .cap_req(cap_req),
    .dst_clk(dst_clk), .dst_rst_n(dst_rst_n),
    .src_code(src_code), .src_bad(src_bad), .dst_code(dst_code), .dst_bad(dst_bad),
    .dst_valid(dst_valid), .dst_new(dst_new)
  );

  // behavioural model of the source domain
  logic [9:0] m_iso;
  int         m_code;
  bit         m_bad;

  function automatic int ref_code(input logic [9:0] v);
    int n = 0, p = 0;
    for (int i = 0; i < N; i++) if (v[i]) begin n++; p = i; end
    return (n == 1) ? p : 15;
  endfunction

  always @(posedge src_clk or negedge src_rst_n)
    if (!src_rst_n) begin
      m_iso = 10'h001; m_code = 0; m_bad = 0;
    end else begin
      m_code = ref_code(m_iso);
      m_bad  = (m_code == 15);
      m_iso  = st_onehot;
    end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison, source domain (R4, R5 and whatever pattern is applied)
  always @(negedge src_clk)
    if (src_rst_n && !done) begin
      chk("R4 src_code vs model", src_code, m_code);
      chk("R5 src_bad vs model", src_bad, m_bad);
    end

  always @(posedge dst_clk) if (dst_rst_n && dst_new) pulses++;

  task automatic src_cycles(input int n);
    repeat (n) @(negedge src_clk);
  endtask

  // requests a capture, returns the pair expected at the destination
  task automatic request(output int ec, output bit eb);
    @(negedge src_clk);
    cap_req = 1'b1;
    ec = m_code; eb = m_bad;
    @(negedge src_clk);
    cap_req = 1'b0;
  endtask

  task automatic wait_pulses(input int target);
    int guard = 0;
    while (pulses < target && guard < 200) begin @(negedge dst_clk); guard++; end
    @(negedge dst_clk);
  endtask

  task automatic summary;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int ec, ec2, p0;
    bit eb, eb2;
    src_cycles(3);
    // R8 reset values
    chk("R8 src_code reset", src_code, 0);
    chk("R8 src_bad reset", src_bad, 0);
    chk("R8 dst_code reset", dst_code, 0);
    chk("R8 dst_bad reset", dst_bad, 0);
    chk("R8 dst_valid reset", dst_valid, 0);
    chk("R8 dst_new reset", dst_new, 0);
    src_rst_n = 1'b1; dst_rst_n = 1'b1;
    src_cycles(2);
    chk("R8 idle code after release", src_code, 0);
    chk("R8 dst_valid after release", dst_valid, 0);

    // R1 walk every state, check latency of two edges
    for (int i = 0; i < N; i++) begin
      @(negedge src_clk); st_onehot = 10'(1) << i;
      @(negedge src_clk);
      chk("R4 no change after one edge", src_code, (i == 0) ? 0 : i - 1);
      @(negedge src_clk);
      chk("R1 state code", src_code, i);
      chk("R1 flag low", src_bad, 0);
    end

    // R2 zero-hot
    @(negedge src_clk); st_onehot = '0;
    src_cycles(2);
    chk("R2 zero-hot code", src_code, 15);
    chk("R2 zero-hot flag", src_bad, 1);

    // R3 multi-hot patterns
    st_onehot = 10'h003; src_cycles(2);
    chk("R3 two bits code", src_code, 15);
    st_onehot = 10'h3FF; src_cycles(2);
    chk("R3 all bits code", src_code, 15);
    st_onehot = 10'h201; src_cycles(2);
    chk("R3 end bits flag", src_bad, 1);

    // R6 capture a legal code, R9 valid follows
    st_onehot = 10'h010; src_cycles(3);
    request(ec, eb);
    wait_pulses(1);
    chk("R6 pulse count", pulses, 1);
    chk("R6 dst_code", dst_code, ec);
    chk("R6 dst_bad", dst_bad, eb);
    chk("R9 dst_valid set", dst_valid, 1);
    src_cycles(12);

    // R6 capture an illegal code
    st_onehot = 10'h000; src_cycles(3);
    request(ec, eb);
    wait_pulses(2);
    chk("R6 bad dst_code", dst_code, 15);
    chk("R6 bad dst_bad", dst_bad, 1);
    src_cycles(12);

    // R7 second request in flight is ignored
    st_onehot = 10'h200; src_cycles(3);
    p0 = pulses;
    request(ec, eb);
    st_onehot = 10'h004; src_cycles(3);
    request(ec2, eb2);
    src_cycles(40);
    chk("R7 one pulse only", pulses, p0 + 1);
    chk("R7 first value kept", dst_code, ec);
    chk("R7 expected first code", ec, 9);
    chk("R10 pulse low", dst_new, 0);
    chk("R9 valid held", dst_valid, 1);

    // R7 after acknowledge returns a new request is served
    request(ec2, eb2);
    wait_pulses(p0 + 2);
    chk("R7 later request served", dst_code, 2);
    chk("R6 later flag", dst_bad, 0);
    src_cycles(4);
    summary();
  end
endmodule